// File: doc/BRIEF.md
# Multiframe Signaling Bit Inserter

This block sits in the transmit path of a T1 or E1 framer. It writes per-channel signaling nibbles (bits A, B, C and D) into an outgoing PCM byte stream. The stream arrives one time slot per valid cycle. Each byte comes with its frame index inside the multiframe, its time-slot index and a strobe that marks the first byte of a multiframe. Framing generation, line coding, elastic storage and the host bus sit outside the block.

Signaling comes from two sources, selected per channel, and both can be in use at once. The first is a host register bank that the host writes at any time. The bank is copied into a shadow store only at a multiframe boundary, so a write made partway through a multiframe takes effect at the next one. A sticky boundary flag, with an optional interrupt, tells the host when it may rewrite the bank. The second is a nibble stream that runs alongside the PCM bytes. The block buffers it per time slot and merges it into the PCM stream. For T1 the nibble is placed by robbed-bit substitution, in ESF or D4 framing. For E1 it is packed into time slot 16 in CAS format, and in CCS format time slot 16 is left alone.

Top module: `sig_inserter`

## Requirements
- R1: `pcm_o` and `pcm_valid_o` are registered. The byte presented with `in_valid_i` high appears one clock later with `pcm_valid_o` high. A cycle with `in_valid_i` low gives `pcm_valid_o` low one clock later.
- R2: Host register byte k holds the nibble of slot 2k in bits 7:4 and the nibble of slot 2k+1 in bits 3:0. In each nibble, bit 3 is A, bit 2 is B, bit 1 is C and bit 0 is D. The bank is copied into the shadow store only on a cycle where `in_valid_i` and `mf_start_i` are both high, so a write made inside a multiframe changes nothing until the next boundary.
- R3: One clock after a boundary byte, `mf_flag_o` is high. It stays high until `flag_clr_i` is asserted, and a boundary in the same cycle as a clear wins. `irq_o` is high exactly when `mf_flag_o` and `irq_en_i` are both high.
- R4: A channel whose bit is set in `sw_en_i` and clear in `hw_sel_i` takes its nibble from the shadow store.
- R5: On every valid byte, the block captures the `sig_i` nibble for that slot. A channel whose bit is set in `hw_sel_i` takes the nibble captured for it before the current byte. This source wins when both mask bits are set.
- R6: In ESF mode (`mode_i` = 0), the LSB of slots 0..23 of an enabled channel is replaced in frames 5, 11, 17 and 23 (counted from 0) by A, B, C and D respectively.
- R7: In D4 mode (`mode_i` = 1), the LSB is replaced only in frames 5 and 11, by A and B. The C and D bits of the nibble have no effect.
- R8: In E1 CAS mode (`mode_i` = 2), the time slot 16 byte of frame n (n = 1..15) carries the nibble of slot n in bits 7:4 and the nibble of slot n+16 in bits 3:0. A half whose channel is not enabled keeps the input bits. The frame 0 time slot 16 byte passes unchanged.
- R9: In E1 CCS mode (`mode_i` = 3), every byte passes unchanged.
- R10: A channel with neither mask bit set passes unchanged, and so does every byte outside the insertion positions above.
- R11: During reset, `pcm_o`, `pcm_valid_o`, `mf_flag_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 0 ESF, 1 D4, 2 E1 CAS, 3 E1 CCS |
| in_valid_i | input | 1 | PCM byte present this cycle |
| mf_start_i | input | 1 | Byte is the first of a multiframe |
| frame_i | input | 5 | Frame index inside the multiframe, from 0 |
| slot_i | input | 5 | Time-slot index inside the frame, from 0 |
| pcm_i | input | 8 | Incoming PCM byte |
| sig_i | input | 4 | Signaling nibble for the current slot (ABCD) |
| sw_en_i | input | 32 | Per-slot enable for the register source |
| hw_sel_i | input | 32 | Per-slot select for the stream source |
| host_wr_i | input | 1 | Host register write strobe |
| host_addr_i | input | 4 | Host register index |
| host_data_i | input | 8 | Host register write data |
| flag_clr_i | input | 1 | Clear the boundary flag |
| irq_en_i | input | 1 | Interrupt enable |
| pcm_o | output | 8 | Outgoing PCM byte with signaling |
| pcm_valid_o | output | 1 | `pcm_o` valid |
| mf_flag_o | output | 1 | Sticky multiframe boundary flag |
| irq_o | output | 1 | Boundary interrupt |

## Verification
Every result of this block is due exactly one clock after the edge that takes its stimulus. This holds for the output byte and its valid, the boundary flag and the clear. The interrupt follows the flag in the same cycle as the flag. The bench drives each byte on a falling edge and samples one time unit after the next rising edge, so each comparison lands in the cycle the result is registered.

The reference model in the bench handles timing in two ways. It moves its own bank into its shadow only after the boundary edge has passed. It updates its per-slot stream buffer only after the byte that carried the nibble has been checked. Because of this, a mid-multiframe host write and the stream values are both checked against the cycle in which they become visible.

// File: rtl/sig_ins_pkg.sv
`timescale 1ns/1ps
package sig_ins_pkg;
    localparam int NSLOT = 32;
    localparam int NIB   = 4;
    localparam int NREG  = NSLOT / 2;
    localparam int AW    = $clog2(NREG);
    localparam int SW    = $clog2(NSLOT);

    typedef enum logic [1:0] {
        MODE_ESF = 2'd0,
        MODE_D4  = 2'd1,
        MODE_CAS = 2'd2,
        MODE_CCS = 2'd3
    } sig_mode_e;

    typedef logic [NSLOT-1:0][NIB-1:0] nib_arr_t;

    typedef struct packed {
        logic [7:0] pcm;
        logic       vld;
        logic       flag;
    } out_state_t;
endpackage

// File: rtl/sig_regbank.sv
`timescale 1ns/1ps
module sig_regbank
    import sig_ins_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   wr_addr_i,
    input  logic [7:0]      wr_data_i,
    input  logic            load_i,
    output nib_arr_t        shadow_o
);
    typedef struct packed {
        logic [NREG-1:0][7:0] bank;
        logic [NREG-1:0][7:0] shad;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.bank[wr_addr_i] = wr_data_i;
        end
        if (load_i) begin
            st_d.shad = st_q.bank;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar k = 0; k < NREG; k++) begin : g_unpack
        assign shadow_o[2*k]   = st_q.shad[k][7:4];
        assign shadow_o[2*k+1] = st_q.shad[k][3:0];
    end
endmodule

// File: rtl/sig_hwbuf.sv
`timescale 1ns/1ps
module sig_hwbuf
    import sig_ins_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic [SW-1:0]   slot_i,
    input  logic [NIB-1:0]  sig_i,
    output nib_arr_t        buf_o
);
    nib_arr_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (valid_i) begin
            buf_d[slot_i] = sig_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign buf_o = buf_q;
endmodule

// File: rtl/sig_merge.sv
`timescale 1ns/1ps
module sig_merge
    import sig_ins_pkg::*;
#(
    parameter int T1_SLOTS = 24
) (
    input  sig_mode_e        mode_i,
    input  logic [4:0]       frame_i,
    input  logic [SW-1:0]    slot_i,
    input  logic [7:0]       pcm_i,
    input  logic [NSLOT-1:0] sw_en_i,
    input  logic [NSLOT-1:0] hw_sel_i,
    input  nib_arr_t         shadow_i,
    input  nib_arr_t         hwbuf_i,
    output logic [7:0]       pcm_o
);
    localparam int LAST_T1 = T1_SLOTS - 1;

    logic [SW-1:0]  hi_idx, lo_idx;
    logic           t1_use, hi_use, lo_use;
    logic [NIB-1:0] t1_nib, hi_nib, lo_nib;

    always_comb begin
        hi_idx = slot_i;
        lo_idx = slot_i;
        if (mode_i == MODE_CAS) begin
            hi_idx = frame_i;
            lo_idx = {1'b1, frame_i[3:0]};
        end
        t1_use = sw_en_i[slot_i] | hw_sel_i[slot_i];
        t1_nib = hw_sel_i[slot_i] ? hwbuf_i[slot_i] : shadow_i[slot_i];
        hi_use = sw_en_i[hi_idx] | hw_sel_i[hi_idx];
        hi_nib = hw_sel_i[hi_idx] ? hwbuf_i[hi_idx] : shadow_i[hi_idx];
        lo_use = sw_en_i[lo_idx] | hw_sel_i[lo_idx];
        lo_nib = hw_sel_i[lo_idx] ? hwbuf_i[lo_idx] : shadow_i[lo_idx];

        pcm_o = pcm_i;
        unique case (mode_i)
            MODE_ESF, MODE_D4: begin
                if ((32'(slot_i) <= LAST_T1) && t1_use) begin
                    unique case (frame_i)
                        5'd5:    pcm_o[0] = t1_nib[3];
                        5'd11:   pcm_o[0] = t1_nib[2];
                        5'd17:   if (mode_i == MODE_ESF) pcm_o[0] = t1_nib[1];
                        5'd23:   if (mode_i == MODE_ESF) pcm_o[0] = t1_nib[0];
                        default: pcm_o = pcm_i;
                    endcase
                end
            end
            MODE_CAS: begin
                if (slot_i == 5'd16 && frame_i != 5'd0 && !frame_i[4]) begin
                    if (hi_use) pcm_o[7:4] = hi_nib;
                    if (lo_use) pcm_o[3:0] = lo_nib;
                end
            end
            default: pcm_o = pcm_i;
        endcase
    end
endmodule

// File: rtl/sig_inserter.sv
`timescale 1ns/1ps
module sig_inserter
    import sig_ins_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  mode_i,
    input  logic        in_valid_i,
    input  logic        mf_start_i,
    input  logic [4:0]  frame_i,
    input  logic [4:0]  slot_i,
    input  logic [7:0]  pcm_i,
    input  logic [3:0]  sig_i,
    input  logic [31:0] sw_en_i,
    input  logic [31:0] hw_sel_i,
    input  logic        host_wr_i,
    input  logic [3:0]  host_addr_i,
    input  logic [7:0]  host_data_i,
    input  logic        flag_clr_i,
    input  logic        irq_en_i,
    output logic [7:0]  pcm_o,
    output logic        pcm_valid_o,
    output logic        mf_flag_o,
    output logic        irq_o
);
    nib_arr_t   shadow, hwbuf;
    logic [7:0] merged;
    logic       boundary;
    out_state_t st_d, st_q;

    assign boundary = in_valid_i & mf_start_i;

    sig_regbank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (host_wr_i),
        .wr_addr_i (host_addr_i),
        .wr_data_i (host_data_i),
        .load_i    (boundary),
        .shadow_o  (shadow)
    );

    sig_hwbuf u_hwbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (in_valid_i),
        .slot_i  (slot_i),
        .sig_i   (sig_i),
        .buf_o   (hwbuf)
    );

    sig_merge #(.T1_SLOTS(24)) u_merge (
        .mode_i   (sig_mode_e'(mode_i)),
        .frame_i  (frame_i),
        .slot_i   (slot_i),
        .pcm_i    (pcm_i),
        .sw_en_i  (sw_en_i),
        .hw_sel_i (hw_sel_i),
        .shadow_i (shadow),
        .hwbuf_i  (hwbuf),
        .pcm_o    (merged)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid_i;
        if (in_valid_i) begin
            st_d.pcm = merged;
        end
        if (boundary) begin
            st_d.flag = 1'b1;
        end else if (flag_clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pcm_o       = st_q.pcm;
    assign pcm_valid_o = st_q.vld;
    assign mf_flag_o   = st_q.flag;
    assign irq_o       = st_q.flag & irq_en_i;
endmodule

// File: rtl/sig_inserter_chk.sv
`timescale 1ns/1ps
module sig_inserter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  mode_i,
    input logic        in_valid_i,
    input logic        mf_start_i,
    input logic [4:0]  slot_i,
    input logic [7:0]  pcm_i,
    input logic [31:0] sw_en_i,
    input logic [31:0] hw_sel_i,
    input logic        flag_clr_i,
    input logic        irq_en_i,
    input logic [7:0]  pcm_o,
    input logic        pcm_valid_o,
    input logic        mf_flag_o,
    input logic        irq_o
);
    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (pcm_valid_o == $past(in_valid_i)));

    assert_flag_on_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && mf_start_i) |=> mf_flag_o);

    assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !(in_valid_i && mf_start_i)) |=> !mf_flag_o);

    assert_irq_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mf_flag_o || !irq_en_i) |-> !irq_o);

    assert_ccs_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && mode_i == 2'd3) |=> (pcm_o == $past(pcm_i)));

    assert_unmasked_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !sw_en_i[slot_i] && !hw_sel_i[slot_i]
         && !(mode_i == 2'd2 && slot_i == 5'd16)) |=> (pcm_o == $past(pcm_i)));
endmodule

bind sig_inserter sig_inserter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .in_valid_i  (in_valid_i),
    .mf_start_i  (mf_start_i),
    .slot_i      (slot_i),
    .pcm_i       (pcm_i),
    .sw_en_i     (sw_en_i),
    .hw_sel_i    (hw_sel_i),
    .flag_clr_i  (flag_clr_i),
    .irq_en_i    (irq_en_i),
    .pcm_o       (pcm_o),
    .pcm_valid_o (pcm_valid_o),
    .mf_flag_o   (mf_flag_o),
    .irq_o       (irq_o)
);

// File: tb/sig_inserter_tb.sv
`timescale 1ns/1ps
module sig_inserter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = '0;
    logic        in_valid_i = 1'b0;
    logic        mf_start_i = 1'b0;
    logic [4:0]  frame_i = '0;
    logic [4:0]  slot_i = '0;
    logic [7:0]  pcm_i = '0;
    logic [3:0]  sig_i = '0;
    logic [31:0] sw_en_i = '0;
    logic [31:0] hw_sel_i = '0;
    logic        host_wr_i = 1'b0;
    logic [3:0]  host_addr_i = '0;
    logic [7:0]  host_data_i = '0;
    logic        flag_clr_i = 1'b0;
    logic        irq_en_i = 1'b0;
    logic [7:0]  pcm_o;
    logic        pcm_valid_o;
    logic        mf_flag_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_bank [16];
    logic [3:0] m_sh   [32];
    logic [3:0] m_hw   [32];

    always #5 clk = ~clk;

    sig_inserter u_dut (.*);

    // {mode, sw_en, hw_sel}
    localparam logic [65:0] SCEN [7] = '{
        {2'd0, 32'h00FF_FFFF, 32'h0000_0000},
        {2'd0, 32'h00F0_F0F0, 32'h000F_F00F},
        {2'd1, 32'h00FF_FFFF, 32'h0000_0F00},
        {2'd2, 32'hFFFF_FFFF, 32'h00FF_00F0},
        {2'd2, 32'h0F0F_0F0F, 32'h0000_0000},
        {2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {2'd0, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit m_use(int ch);
        return sw_en_i[ch] | hw_sel_i[ch];
    endfunction

    function automatic logic [3:0] m_nib(int ch);
        return hw_sel_i[ch] ? m_hw[ch] : m_sh[ch];
    endfunction

    function automatic string m_src(int ch);
        return hw_sel_i[ch] ? "R5" : "R4 R2";
    endfunction

    function automatic logic [7:0] model(int md, int fr, int sl, logic [7:0] d, output string tag);
        logic [7:0] r = d;
        logic [3:0] n;
        tag = "R10";
        if (md == 3) begin
            tag = "R9";
        end else if (md == 2) begin
            if (sl == 16) begin
                tag = "R8";
                if (fr >= 1 && fr <= 15) begin
                    if (m_use(fr)) begin r[7:4] = m_nib(fr); tag = {tag, " ", m_src(fr)}; end
                    if (m_use(fr + 16)) begin r[3:0] = m_nib(fr + 16); tag = {tag, " ", m_src(fr + 16)}; end
                end
            end
        end else if (sl < 24 && m_use(sl)) begin
            n = m_nib(sl);
            if (fr == 5) begin r[0] = n[3]; tag = (md == 0) ? "R6" : "R7"; end
            else if (fr == 11) begin r[0] = n[2]; tag = (md == 0) ? "R6" : "R7"; end
            else if (md == 0 && fr == 17) begin r[0] = n[1]; tag = "R6"; end
            else if (md == 0 && fr == 23) begin r[0] = n[0]; tag = "R6"; end
            else if (md == 1) tag = "R7";
            if (tag != "R10" && !(md == 1 && fr != 5 && fr != 11)) tag = {tag, " ", m_src(sl)};
        end
        return r;
    endfunction

    task automatic send(input bit mf, input int fr, input int sl);
        logic [7:0] exp;
        logic [31:0] rnd;
        string tag;
        @(negedge clk);
        rnd = $urandom();
        in_valid_i = 1'b1;
        mf_start_i = mf;
        frame_i    = 5'(fr);
        slot_i     = 5'(sl);
        pcm_i      = rnd[7:0];
        sig_i      = rnd[11:8];
        exp = model(int'(mode_i), fr, sl, rnd[7:0], tag);
        @(posedge clk);
        #1;
        check({tag, " data"}, {24'd0, pcm_o}, {24'd0, exp});
        check("R1 valid", {31'd0, pcm_valid_o}, 32'd1);
        if (mf) begin
            for (int k = 0; k < 16; k++) begin
                m_sh[2*k]   = m_bank[k][7:4];
                m_sh[2*k+1] = m_bank[k][3:0];
            end
        end
        m_hw[sl] = rnd[11:8];
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid_i = 1'b0;
        mf_start_i = 1'b0;
        host_wr_i  = 1'b0;
        flag_clr_i = 1'b0;
    endtask

    task automatic hwrite(input int a, input logic [7:0] v);
        @(negedge clk);
        in_valid_i  = 1'b0;
        mf_start_i  = 1'b0;
        host_wr_i   = 1'b1;
        host_addr_i = 4'(a);
        host_data_i = v;
        @(posedge clk);
        #1;
        host_wr_i = 1'b0;
        m_bank[a] = v;
    endtask

    task automatic run_mf(input int md, input bit mid_write);
        int nfr = (md == 0) ? 24 : (md == 1) ? 12 : 16;
        int nsl = (md >= 2) ? 32 : 24;
        logic [31:0] rnd;
        for (int f = 0; f < nfr; f++) begin
            if (mid_write && f == 8) begin
                // R2: rewrite part of the bank halfway through
                for (int k = 0; k < 16; k += 3) begin
                    rnd = $urandom();
                    hwrite(k, rnd[7:0]);
                end
            end
            for (int s = 0; s < nsl; s++) begin
                send(f == 0 && s == 0, f, s);
            end
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rnd;
        for (int k = 0; k < 32; k++) begin
            m_sh[k] = '0;
            m_hw[k] = '0;
        end
        for (int k = 0; k < 16; k++) m_bank[k] = '0;
        irq_en_i = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R11 pcm", {24'd0, pcm_o}, 32'd0);
        check("R11 valid", {31'd0, pcm_valid_o}, 32'd0);
        check("R11 flag", {31'd0, mf_flag_o}, 32'd0);
        check("R11 irq", {31'd0, irq_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 7; i++) begin
            mode_i   = SCEN[i][65:64];
            sw_en_i  = SCEN[i][63:32];
            hw_sel_i = SCEN[i][31:0];
            for (int k = 0; k < 16; k++) begin
                rnd = $urandom();
                hwrite(k, rnd[7:0]);
            end
            run_mf(int'(mode_i), 1'b1);
            run_mf(int'(mode_i), 1'b0);
            idle();
        end

        // R1: idle cycle gives low valid
        @(posedge clk);
        #1;
        check("R1 idle valid", {31'd0, pcm_valid_o}, 32'd0);

        // R3: flag sticky, irq gating, clear, boundary beats clear
        check("R3 flag set", {31'd0, mf_flag_o}, 32'd1);
        check("R3 irq on", {31'd0, irq_o}, 32'd1);
        @(negedge clk);
        irq_en_i = 1'b0;
        #1;
        check("R3 irq masked", {31'd0, irq_o}, 32'd0);
        flag_clr_i = 1'b1;
        @(posedge clk);
        #1;
        check("R3 flag cleared", {31'd0, mf_flag_o}, 32'd0);
        @(negedge clk);
        irq_en_i   = 1'b1;
        flag_clr_i = 1'b1;
        in_valid_i = 1'b1;
        mf_start_i = 1'b1;
        mode_i     = 2'd3;
        @(posedge clk);
        #1;
        check("R3 set beats clear", {31'd0, mf_flag_o}, 32'd1);
        check("R3 irq follows", {31'd0, irq_o}, 32'd1);
        idle();

        // R7: C/D bits ignored in D4 frames 17/23, R8 frame 0 pass
        mode_i   = 2'd1;
        sw_en_i  = 32'hFFFF_FFFF;
        hw_sel_i = 32'h0;
        send(1'b0, 17, 3);
        send(1'b0, 23, 4);
        mode_i = 2'd2;
        send(1'b0, 0, 16);
        idle();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule